// File: doc/BRIEF.md
# Pulse-Rejecting Programmable Delay Line

This block delays a multi-bit signal by a programmable number of clock cycles and can optionally filter out short pulses on the way. In transport mode it acts as a plain shift register: every input value, even one held for a single cycle, reappears at the output a fixed number of cycles later. In inertial mode a new input value reaches the output only if the input held it for a minimum number of consecutive cycles. A shorter pulse is dropped, and the output keeps its last accepted value.

The delay D and the rejection limit R are separate static settings, and time is counted in clock cycles. A rejection limit of zero or one turns inertial mode into transport mode. A mode bit can instead tie R to D. A setting that is out of range is clamped to a legal value and sets a sticky error flag. The configuration is assumed stable between resets.

Top module: `pulse_filter_delay`

## Requirements
- R1: While `rst` is high at a rising edge, the whole delay history and `dout` load `INIT_VAL` and `cfg_err` clears. For the first D cycles after reset, `dout` shows `INIT_VAL`.
- R2: With `cfg_inertial` = 0, a value sampled on `din` at rising edge n is shown on `dout` right after edge n+D-1 (D cycles of latency, with D = 1 meaning visible after the sampling edge). Every value passes, including single-cycle pulses.
- R3: With `cfg_inertial` = 1, a value that `din` holds for at least R consecutive sampled cycles appears on `dout` with exactly the same latency as in R2.
- R4: With `cfg_inertial` = 1, a run shorter than R cycles never appears on `dout`, not even for one cycle. While such a run would be on screen, `dout` keeps the last accepted value.
- R5: With `cfg_reject_from_delay` = 1, the effective R equals the effective D and `cfg_reject` is ignored.
- R6: With `cfg_inertial` = 1 and an effective R of 0 or 1, `dout` matches transport mode cycle for cycle.
- R7: When the requested R exceeds the effective D, R is clamped to D. `cfg_err` then rises after the next edge outside reset and stays high until reset.
- R8: A `cfg_delay` of 0 is treated as 1, and a value above `DMAX` is treated as `DMAX`. Either case also sets the sticky `cfg_err`.
- R9: Delays up to `DMAX` (default 16) are supported, including the settings D=2/R=2, D=10/R=5 and D=16/R=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Data input |
| cfg_delay | input | $clog2(DMAX+1) | Requested delay D in cycles |
| cfg_reject | input | $clog2(DMAX+1) | Requested rejection limit R in cycles |
| cfg_reject_from_delay | input | 1 | 1: R follows D |
| cfg_inertial | input | 1 | 0: transport, 1: inertial |
| dout | output | W | Delayed, filtered data |
| cfg_err | output | 1 | Sticky flag for a clamped configuration |

## Verification
Two functions can meet in one output cycle. A spike is suppressed at the same moment a new run that qualifies is released, so the output must move straight from the old held value to the new one without ever showing the spike. The bench provokes this by sending pulses of length R-1 immediately followed by runs of exactly R cycles, as well as random run lengths around R. A behavioural queue model predicts the output for every cycle, and the output is compared against it after each edge.

// File: rtl/pulse_filter_delay.sv
module pulse_filter_delay #(
  parameter int W = 8,
  parameter int DMAX = 16,
  parameter logic [W-1:0] INIT_VAL = '0,
  localparam int DW = $clog2(DMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [DW-1:0] cfg_delay,
  input  logic [DW-1:0] cfg_reject,
  input  logic          cfg_reject_from_delay,
  input  logic          cfg_inertial,
  output logic [W-1:0]  dout,
  output logic          cfg_err
);

  logic [W-1:0]  hist [DMAX];
  logic [W-1:0]  nxt  [DMAX];
  logic [W-1:0]  cand, q;
  logic [DW-1:0] d_eff, r_raw, r_eff;
  logic          d_bad, r_bad, run_ok, err_q;

  assign d_bad = (cfg_delay == '0) || (cfg_delay > DW'(DMAX));
  assign d_eff = (cfg_delay == '0)        ? DW'(1) :
                 (cfg_delay > DW'(DMAX))  ? DW'(DMAX) : cfg_delay;
  assign r_raw = cfg_reject_from_delay ? d_eff : cfg_reject;
  assign r_bad = r_raw > d_eff;
  assign r_eff = r_bad ? d_eff : r_raw;

  always_comb begin
    nxt[0] = din;
    for (int k = 1; k < DMAX; k++) nxt[k] = hist[k-1];
  end

  always_comb begin
    cand = nxt[0];
    for (int k = 0; k < DMAX; k++)
      if (k == int'(d_eff) - 1) cand = nxt[k];
  end

  always_comb begin
    run_ok = 1'b1;
    for (int k = 0; k < DMAX; k++)
      if (k >= int'(d_eff) - int'(r_eff) && k < int'(d_eff) && nxt[k] != cand)
        run_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DMAX; k++) hist[k] <= INIT_VAL;
      q     <= INIT_VAL;
      err_q <= 1'b0;
    end else begin
      for (int k = 0; k < DMAX; k++) hist[k] <= nxt[k];
      if (!cfg_inertial || run_ok) q <= cand;
      err_q <= err_q | d_bad | r_bad;
    end
  end

  assign dout    = q;
  assign cfg_err = err_q;

endmodule

// File: rtl/pulse_filter_delay_chk.sv
module pulse_filter_delay_chk #(
  parameter int W = 8,
  parameter int DMAX = 16,
  parameter logic [W-1:0] INIT_VAL = '0,
  localparam int DW = $clog2(DMAX + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  din,
  input logic [DW-1:0] cfg_delay,
  input logic [DW-1:0] cfg_reject,
  input logic          cfg_reject_from_delay,
  input logic          cfg_inertial,
  input logic [W-1:0]  dout,
  input logic          cfg_err
);

  logic [W-1:0] ch [DMAX];
  int d, r_req, r;

  always_comb begin
    d = int'(cfg_delay);
    if (d < 1) d = 1;
    if (d > DMAX) d = DMAX;
    r_req = cfg_reject_from_delay ? d : int'(cfg_reject);
    r = (r_req > d) ? d : r_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DMAX; k++) ch[k] <= INIT_VAL;
    end else begin
      ch[0] <= din;
      for (int k = 1; k < DMAX; k++) ch[k] <= ch[k-1];
    end
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (dout == INIT_VAL && !cfg_err));

  assert_transport_copy_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_inertial |-> dout == ch[d-1]);

  assert_inertial_source_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_inertial && dout != $past(dout)) |-> dout == ch[d-1]);

  assert_no_glitch_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_inertial && r >= 2 && dout != $past(dout)) |=> $stable(dout));

  assert_zero_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_inertial && r <= 1) |-> dout == ch[d-1]);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_reject_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (r_req > d) |=> cfg_err);

  assert_delay_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg_delay) < 1 || int'(cfg_delay) > DMAX) |=> cfg_err);

endmodule

bind pulse_filter_delay pulse_filter_delay_chk #(
  .W(W), .DMAX(DMAX), .INIT_VAL(INIT_VAL)
) chk_i (
  .clk(clk), .rst(rst), .din(din), .cfg_delay(cfg_delay),
  .cfg_reject(cfg_reject), .cfg_reject_from_delay(cfg_reject_from_delay),
  .cfg_inertial(cfg_inertial), .dout(dout), .cfg_err(cfg_err)
);

// File: tb/pulse_filter_delay_tb.sv
module pulse_filter_delay_tb_top;
  localparam int W = 8;
  localparam int DMAX = 16;
  localparam int DW = $clog2(DMAX + 1);
  localparam logic [W-1:0] INIT = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] din = INIT;
  logic [DW-1:0] cfg_delay = DW'(2), cfg_reject = DW'(2);
  logic cfg_rfd = 1'b0, cfg_inertial = 1'b1;
  logic [W-1:0] dout;
  logic cfg_err;

  int checks = 0, errors = 0;
  logic [W-1:0] mq [$];
  logic [W-1:0] exp_q;
  bit err_m, illegal;
  int md, mr;

  always #2 clk = ~clk;

  pulse_filter_delay #(.W(W), .DMAX(DMAX), .INIT_VAL(INIT)) dut_i (
    .clk(clk), .rst(rst), .din(din), .cfg_delay(cfg_delay),
    .cfg_reject(cfg_reject), .cfg_reject_from_delay(cfg_rfd),
    .cfg_inertial(cfg_inertial), .dout(dout), .cfg_err(cfg_err));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic configure(input int d, input int r, input bit rfd, input bit inert);
    cfg_delay = DW'(d); cfg_reject = DW'(r); cfg_rfd = rfd; cfg_inertial = inert;
    illegal = 0;
    md = d;
    if (md < 1) begin md = 1; illegal = 1; end
    if (md > DMAX) begin md = DMAX; illegal = 1; end
    mr = rfd ? md : r;
    if (mr > md) begin mr = md; illegal = 1; end
  endtask

  // R1: reset loads history and output with INIT, clears the flag
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(dout == INIT, "R1", "dout in reset", dout, INIT);
    check(cfg_err == 1'b0, "R1", "err in reset", {7'b0, cfg_err}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    for (int k = 0; k < DMAX; k++) mq.push_back(INIT);
    exp_q = INIT;
    err_m = 0;
  endtask

  task automatic cyc(input logic [W-1:0] v, input string tag);
    logic [W-1:0] cand;
    bit ok;
    din = v;
    @(posedge clk);
    #1;
    mq.push_front(v);
    void'(mq.pop_back());
    if (illegal) err_m = 1;
    cand = mq[md-1];
    ok = 1;
    for (int k = md - mr; k < md; k++) if (mq[k] != cand) ok = 0;
    if (!cfg_inertial || ok) exp_q = cand;
    check(dout == exp_q, tag, "dout", dout, exp_q);
    check(cfg_err == err_m, tag, "cfg_err", {7'b0, cfg_err}, {7'b0, err_m});
    @(negedge clk);
  endtask

  task automatic hold(input logic [W-1:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(v, tag);
  endtask

  task automatic random_runs(input int nruns, input int maxlen, input string tag);
    logic [W-1:0] v;
    v = INIT;
    for (int i = 0; i < nruns; i++) begin
      v = W'($urandom);
      hold(v, $urandom_range(1, maxlen), tag);
    end
    hold(v, DMAX + 2, tag);
  endtask

  // spike of len r-1, then a qualifying run of exactly r (suppress + release meet)
  task automatic spike_then_run(input int r, input string tag);
    hold(8'h11, DMAX + 2, tag);
    if (r > 1) hold(8'hEE, r - 1, tag);
    hold(8'h5A, r, tag);
    hold(8'h11, DMAX + 2, tag);
  endtask

  initial begin
    @(negedge clk);
    configure(2, 2, 0, 1);
    do_reset();

    configure(3, 0, 0, 0);
    do_reset();
    hold(8'h3C, 1, "R2"); hold(8'h00, 5, "R2"); hold(8'hFF, 1, "R2");
    random_runs(60, 3, "R2");

    configure(2, 2, 0, 1);
    do_reset();
    hold(8'h77, 1, "R4"); hold(INIT, 6, "R4");
    hold(8'h77, 2, "R3"); hold(INIT, 6, "R3");
    spike_then_run(2, "R4");
    random_runs(80, 4, "R3");

    configure(10, 5, 0, 1);
    do_reset();
    for (int len = 1; len <= 7; len++) begin
      hold(8'h42, len, len < 5 ? "R4" : "R3");
      hold(8'h24, 12, "R9");
    end
    spike_then_run(5, "R4");
    random_runs(80, 8, "R3");

    configure(4, 0, 1, 1);
    do_reset();
    hold(8'h99, 3, "R5"); hold(INIT, 8, "R5");
    hold(8'h99, 4, "R5"); hold(INIT, 8, "R5");
    random_runs(40, 6, "R5");

    configure(5, 0, 0, 1);
    do_reset();
    hold(8'h81, 1, "R6"); hold(INIT, 8, "R6");
    random_runs(60, 3, "R6");
    configure(5, 1, 0, 1);
    do_reset();
    random_runs(60, 2, "R6");

    configure(3, 7, 0, 1);
    do_reset();
    hold(8'h61, 2, "R7"); hold(INIT, 6, "R7");
    hold(8'h61, 3, "R7"); hold(INIT, 6, "R7");
    do_reset();
    hold(INIT, 4, "R1");

    configure(0, 0, 0, 0);
    do_reset();
    random_runs(30, 3, "R8");
    configure(20, 3, 0, 1);
    do_reset();
    random_runs(40, 5, "R8");

    configure(16, 16, 0, 1);
    do_reset();
    spike_then_run(16, "R9");
    random_runs(40, 20, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule